// File: doc/BRIEF.md
# Instruction Access Exception Prioritizer

This block sits beside the issue stage of a processor pipeline. Each decoded instruction arrives with a strobe, a set of attribute flags and the current processor status bits. The block checks the instruction against those status bits and raises no more than one access exception request for it. The rules are tested in a fixed order, and the first rule that applies decides the outcome.

Two of the tiers are gates. When floating-point support is off, that tier settles the outcome for the instruction, even if it raises nothing. The same holds for media support. In both cases the media and privilege tests further down are never reached. The result is registered and shows one cycle after the strobe, as a one-hot request vector together with a response-valid pulse. Vectoring, queuing and handler entry belong to other blocks.

Top module: `acc_exc_prio`

## Requirements
- R1: When attr_i[0] (bundle-constraint violation) is set, the response is exc_o bit 0 (illegal instruction), whatever the other inputs are.
- R2: When R1 does not apply, attr_i[1] (non-excepting) is set and stat_i[0] (non-excepting enable) is clear, the response is exc_o bit 1 (not implemented).
- R3: When R1 and R2 do not apply, attr_i[2] (conditional) is set and stat_i[1] (conditional enable) is clear, the response is exc_o bit 1 (not implemented).
- R4: When R1 to R3 do not apply and stat_i[2] (float enable) is clear, the response is exc_o bit 2 (float disabled) in two cases: attr_i[3] (float op) is set, or attr_i[5] (floating-register access) is set while stat_i[3] (media enable) is also clear.
- R5: When stat_i[2] is clear and R4 raises nothing, exc_o stays zero, even for media, media-trap or privileged instructions.
- R6: When R1 to R3 do not apply, stat_i[2] is set and stat_i[3] is clear, the response is exc_o bit 3 (media disabled) if attr_i[4] (media op) or attr_i[7] (media-trap opcode) is set. Otherwise exc_o stays zero, even for a privileged instruction.
- R7: When all earlier tiers pass and both enables are set, an instruction with attr_i[6] (privileged) set and stat_i[4] (supervisor) clear gives exc_o bit 4 (privileged instruction).
- R8: exc_o has at most one bit set. Each accepted strobe gives rsp_valid_o high on the following clock cycle, and strobes may come back to back.
- R9: A cycle with in_valid_i low gives rsp_valid_o and exc_o low on the next cycle. A synchronous active-high rst_i clears both outputs.
- R10: A valid instruction that matches no rule gives rsp_valid_o high with exc_o zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction strobe |
| attr_i | input | 8 | Instruction attribute flags, bit positions as in R1 to R7 |
| stat_i | input | 5 | Processor status bits, bit positions as in R2 to R7 |
| rsp_valid_o | output | 1 | Response pulse, one cycle after each strobe |
| exc_o | output | 5 | One-hot exception request, zero when nothing is raised |

## Verification
The bench runs every combination of attribute flags and status bits and compares each response with a model of the rules. This exhaustive pass shows whether the ordering between tiers is right. Directed cases set a higher tier and a lower tier together, so that a wrong ordering shows up as the wrong bit. Other directed cases pair a disabled float or media tier with a privileged instruction, which separates a gate that stops the chain from a check that only falls through. Idle cycles, back-to-back strobes and reset show whether the output register pulses and clears correctly.

// File: rtl/acc_exc_pkg.sv
package acc_exc_pkg;

    // attribute flag positions
    localparam int A_BUNDLE = 0;
    localparam int A_NOEXC  = 1;
    localparam int A_COND   = 2;
    localparam int A_FLOAT  = 3;
    localparam int A_MEDIA  = 4;
    localparam int A_FRACC  = 5;
    localparam int A_PRIV   = 6;
    localparam int A_MTRAP  = 7;
    localparam int ATTR_W   = 8;

    // status bit positions
    localparam int S_NOEXC_EN = 0;
    localparam int S_COND_EN  = 1;
    localparam int S_FLOAT_EN = 2;
    localparam int S_MEDIA_EN = 3;
    localparam int S_SUPER    = 4;
    localparam int STAT_W     = 5;

    // exception request bit positions
    localparam int E_ILLEGAL = 0;
    localparam int E_UNIMPL  = 1;
    localparam int E_FPOFF   = 2;
    localparam int E_MPOFF   = 3;
    localparam int E_PRIV    = 4;
    localparam int EXC_W     = 5;

    // priority tiers, highest first
    typedef enum int {
        T_BUNDLE = 0,
        T_NOEXC  = 1,
        T_COND   = 2,
        T_FLOAT  = 3,
        T_MEDIA  = 4,
        T_PRIV   = 5
    } tier_e;
    localparam int NUM_TIERS = 6;

    typedef struct packed {
        logic             vld;
        logic [EXC_W-1:0] exc;
    } rsp_t;

    function automatic logic [EXC_W-1:0] tier_exc(input int t);
        logic [EXC_W-1:0] v;
        v = '0;
        case (t)
            T_BUNDLE: v[E_ILLEGAL] = 1'b1;
            T_NOEXC:  v[E_UNIMPL]  = 1'b1;
            T_COND:   v[E_UNIMPL]  = 1'b1;
            T_FLOAT:  v[E_FPOFF]   = 1'b1;
            T_MEDIA:  v[E_MPOFF]   = 1'b1;
            T_PRIV:   v[E_PRIV]    = 1'b1;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/acc_exc_tiers.sv
module acc_exc_tiers
    import acc_exc_pkg::*;
#(
    parameter int AW = ATTR_W,
    parameter int SW = STAT_W,
    parameter int NT = NUM_TIERS
) (
    input  logic [AW-1:0] attr_i,
    input  logic [SW-1:0] stat_i,
    output logic [NT-1:0] hit_o,
    output logic [NT-1:0] stop_o
);

    logic fp_off;
    logic mp_off;

    always_comb begin
        fp_off = ~stat_i[S_FLOAT_EN];
        mp_off = ~stat_i[S_MEDIA_EN];

        hit_o  = '0;
        stop_o = '0;

        hit_o[T_BUNDLE] = attr_i[A_BUNDLE];
        hit_o[T_NOEXC]  = attr_i[A_NOEXC] & ~stat_i[S_NOEXC_EN];
        hit_o[T_COND]   = attr_i[A_COND]  & ~stat_i[S_COND_EN];

        // gate tier: float support off ends the chain here
        hit_o[T_FLOAT]  = fp_off & (attr_i[A_FLOAT] | (attr_i[A_FRACC] & mp_off));
        stop_o[T_FLOAT] = fp_off;

        // gate tier: media support off ends the chain here
        hit_o[T_MEDIA]  = mp_off & (attr_i[A_MEDIA] | attr_i[A_MTRAP]);
        stop_o[T_MEDIA] = mp_off;

        hit_o[T_PRIV]   = attr_i[A_PRIV] & ~stat_i[S_SUPER];
    end

endmodule

// File: rtl/acc_exc_chain.sv
module acc_exc_chain #(
    parameter int NT = 6
) (
    input  logic [NT-1:0] hit_i,
    input  logic [NT-1:0] stop_i,
    output logic [NT-1:0] grant_o
);

    logic [NT:0] live;

    // a tier is reached only if no earlier tier hit or stopped the chain
    always_comb begin
        live[0] = 1'b1;
        for (int i = 0; i < NT; i++) begin
            grant_o[i] = live[i] & hit_i[i];
            live[i+1]  = live[i] & ~hit_i[i] & ~stop_i[i];
        end
    end

endmodule

// File: rtl/acc_exc_prio.sv
module acc_exc_prio
    import acc_exc_pkg::*;
#(
    parameter int AW = ATTR_W,
    parameter int SW = STAT_W,
    parameter int EW = EXC_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          in_valid_i,
    input  logic [AW-1:0] attr_i,
    input  logic [SW-1:0] stat_i,
    output logic          rsp_valid_o,
    output logic [EW-1:0] exc_o
);

    localparam int NT = NUM_TIERS;

    logic [NT-1:0] hit;
    logic [NT-1:0] stop;
    logic [NT-1:0] grant;
    logic [EW-1:0] exc_map;

    rsp_t rsp_d;
    rsp_t rsp_q;

    acc_exc_tiers #(.AW(AW), .SW(SW), .NT(NT)) u_tiers (
        .attr_i (attr_i),
        .stat_i (stat_i),
        .hit_o  (hit),
        .stop_o (stop)
    );

    acc_exc_chain #(.NT(NT)) u_chain (
        .hit_i   (hit),
        .stop_i  (stop),
        .grant_o (grant)
    );

    // map the single granted tier onto its exception request
    always_comb begin
        exc_map = '0;
        for (int t = 0; t < NT; t++) begin
            if (grant[t]) exc_map = exc_map | tier_exc(t);
        end
    end

    always_comb begin
        rsp_d = '0;
        if (in_valid_i) begin
            rsp_d.vld = 1'b1;
            rsp_d.exc = exc_map;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rsp_q <= '0;
        else       rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.vld;
    assign exc_o       = rsp_q.exc;

endmodule

// File: rtl/acc_exc_prio_chk.sv
module acc_exc_prio_chk
    import acc_exc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              in_valid_i,
    input logic [ATTR_W-1:0] attr_i,
    input logic [STAT_W-1:0] stat_i,
    input logic              rsp_valid_o,
    input logic [EXC_W-1:0]  exc_o
);

    // R8
    onehot_exc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(exc_o));

    // R8
    pulse_follows_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> rsp_valid_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> (!rsp_valid_o && exc_o == '0));

    // R1
    bundle_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && attr_i[A_BUNDLE]) |=> exc_o[E_ILLEGAL]);

    // R5
    float_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && !stat_i[S_FLOAT_EN]) |=> (!exc_o[E_MPOFF] && !exc_o[E_PRIV]));

    // R6
    media_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && !stat_i[S_MEDIA_EN]) |=> !exc_o[E_PRIV]);

    // R7
    super_ok_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && stat_i[S_SUPER]) |=> !exc_o[E_PRIV]);

endmodule

bind acc_exc_prio acc_exc_prio_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .attr_i      (attr_i),
    .stat_i      (stat_i),
    .rsp_valid_o (rsp_valid_o),
    .exc_o       (exc_o)
);

// File: tb/acc_exc_prio_tb.sv
module acc_exc_prio_tb;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       in_valid_i = 1'b0;
    logic [7:0] attr_i = '0;
    logic [4:0] stat_i = '0;
    logic       rsp_valid_o;
    logic [4:0] exc_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk_i = ~clk_i;

    acc_exc_prio u_dut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .in_valid_i  (in_valid_i),
        .attr_i      (attr_i),
        .stat_i      (stat_i),
        .rsp_valid_o (rsp_valid_o),
        .exc_o       (exc_o)
    );

    // expected request written from the requirement list
    function automatic logic [4:0] model(input logic [7:0] a, input logic [4:0] s);
        if (a[0])                     return 5'b00001;
        else if (a[1] && !s[0])       return 5'b00010;
        else if (a[2] && !s[1])       return 5'b00010;
        else if (!s[2])               return (a[3] || (a[5] && !s[3])) ? 5'b00100 : 5'b0;
        else if (!s[3])               return (a[4] || a[7]) ? 5'b01000 : 5'b0;
        else if (a[6] && !s[4])       return 5'b10000;
        else                          return 5'b0;
    endfunction

    task automatic check(input logic ev, input logic [4:0] ee, input string tag);
        total++;
        if (rsp_valid_o !== ev || exc_o !== ee) begin
            bad++;
            $display("FAIL %s: got vld=%b exc=%b expected vld=%b exc=%b",
                     tag, rsp_valid_o, exc_o, ev, ee);
        end
    endtask

    // one strobe, checked at the negedge after the capturing posedge
    task automatic issue(input logic [7:0] a, input logic [4:0] s,
                         input logic [4:0] ee, input string tag);
        @(negedge clk_i);
        in_valid_i = 1'b1; attr_i = a; stat_i = s;
        @(negedge clk_i);
        in_valid_i = 1'b0;
        check(1'b1, ee, tag);
    endtask

    task automatic t_reset();
        check(1'b0, 5'b0, "R9 reset state");
    endtask

    task automatic t_priority();
        issue(8'b1111_1111, 5'b00000, 5'b00001, "R1 bundle over all");
        issue(8'b0100_0110, 5'b00010, 5'b00010, "R2 non-excepting");
        issue(8'b0100_0100, 5'b00001, 5'b00010, "R3 conditional");
        issue(8'b0000_1000, 5'b11011, 5'b00100, "R4 float op");
        issue(8'b0010_0000, 5'b10011, 5'b00100, "R4 fr access media off");
        issue(8'b0010_0000, 5'b11011, 5'b00000, "R4 fr access media on");
    endtask

    task automatic t_gates();
        issue(8'b1101_0000, 5'b00011, 5'b00000, "R5 float gate hides media and priv");
        issue(8'b0101_0000, 5'b00111, 5'b01000, "R6 media op");
        issue(8'b1000_0000, 5'b00111, 5'b01000, "R6 media trap");
        issue(8'b0100_0000, 5'b00111, 5'b00000, "R6 media gate hides priv");
        issue(8'b0100_0000, 5'b01111, 5'b10000, "R7 privileged user");
        issue(8'b0100_0000, 5'b11111, 5'b00000, "R10 privileged supervisor");
        issue(8'b0000_0000, 5'b00000, 5'b00000, "R10 clean instruction");
    endtask

    task automatic t_idle();
        @(negedge clk_i);
        attr_i = 8'hFF; stat_i = '0; in_valid_i = 1'b0;
        @(negedge clk_i);
        check(1'b0, 5'b0, "R9 no strobe");
    endtask

    task automatic t_back_to_back();
        @(negedge clk_i);
        in_valid_i = 1'b1; attr_i = 8'b0000_0001; stat_i = 5'b11111;
        @(negedge clk_i);
        check(1'b1, 5'b00001, "R8 b2b first");
        attr_i = 8'b0100_0000; stat_i = 5'b01111;
        @(negedge clk_i);
        check(1'b1, 5'b10000, "R8 b2b second");
        in_valid_i = 1'b0;
        @(negedge clk_i);
        check(1'b0, 5'b0, "R9 after b2b");
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 8192; c++) begin
            logic [7:0] a;
            logic [4:0] s;
            logic [4:0] e;
            a = c[7:0];
            s = c[12:8];
            e = model(a, s);
            @(negedge clk_i);
            in_valid_i = 1'b1; attr_i = a; stat_i = s;
            @(negedge clk_i);
            total++;
            if (rsp_valid_o !== 1'b1 || exc_o !== e || $countones(exc_o) > 1) begin
                bad++;
                $display("FAIL R8 sweep a=%b s=%b: got exc=%b vld=%b expected exc=%b vld=1",
                         a, s, exc_o, rsp_valid_o, e);
            end
        end
        in_valid_i = 1'b0;
    endtask

    task automatic t_mid_reset();
        @(negedge clk_i);
        in_valid_i = 1'b1; attr_i = 8'h01; stat_i = '0; rst_i = 1'b1;
        @(negedge clk_i);
        check(1'b0, 5'b0, "R9 reset clears");
        rst_i = 1'b0; in_valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_i = 1'b0;
        t_priority();
        t_gates();
        t_idle();
        t_back_to_back();
        t_sweep();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule